// File: doc/BRIEF.md
# Quad SPI Flash Continuous-Read Front-End

This block is the device-side serial front-end of a quad-I/O flash memory. It watches chip select, the serial clock and four data lines. It recognises two commands: a one-byte write to a volatile configuration byte, and a quad I/O fast read. It can also run a continuous-read mode, in which every selected transfer begins directly with a 24-bit address and carries no opcode. Read data comes from a small internal byte array and is driven on all four lines, under output-enable control, once the dummy cycles have elapsed.

The serial pins are oversampled by the system clock. Serial inputs are captured on rising serial-clock edges and output nibbles change on falling edges, so a host may use clock idle-low (mode 0) or idle-high (mode 3). To enter continuous-read mode, the host clears the arm bit of the configuration byte. It then issues one quad read and holds DQ0 low in the first dummy cycle. Holding DQ0 high in that cycle leaves the mode. A build parameter allows direct entry without the arm step.

Top module: `qspi_xip_engine`

## Requirements
- R1: After reset dq_oe_o is 0, xip_o is 0 and the configuration byte is FFh: 15 dummy cycles, not armed.
- R2: Opcode 81h is shifted on DQ0, MSB first, one bit per rising serial edge. The next 8 DQ0 bits, MSB first, replace the configuration byte. Bits [7:4] are the dummy count and bit 3 is the arm bit (0 = armed).
- R3: Opcode EBh is followed by 6 quad address clocks, high nibble first, with DQ3..DQ0 carrying address bits 4k+3..4k. Then come N dummy clocks, where N = cfg[7:4] and a value of 0 means 1. Then come data nibbles, bits 7:4 of each byte first.
- R4: DQ0 in the first dummy clock is the confirm bit. A 0 sets xip_o only if xip_o is already 1, or the arm bit is 0, or DIRECT_ENTRY=1. Otherwise xip_o is unchanged.
- R5: A confirm bit of 1 clears xip_o. The read in progress still returns its data.
- R6: While xip_o is 1, each selected transfer starts at the address phase with no opcode.
- R7: The byte at array index i is ((i*29) mod 256) XOR 5Ah. The index is the address modulo MEM_DEPTH. After each byte the address increments, wrapping at the end of the array.
- R8: Raising cs_ni aborts any phase. dq_oe_o falls to 0 and xip_o keeps its value.
- R9: Opcodes other than 81h and EBh are ignored until deselect: no output is driven, and the configuration and xip_o stay unchanged.
- R10: dq_oe_o rises and dq_o changes only after a falling serial edge. The data lines switch to output on the falling edge that ends the last dummy clock, in both mode 0 and mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low chip select |
| dq_i | input | 4 | Data lines, input side |
| dq_o | output | 4 | Data lines, output side |
| dq_oe_o | output | 4 | Output enable for each data line |
| xip_o | output | 1 | Continuous-read mode flag |

## Verification
The assertions assume that sclk_i, cs_ni and dq_i are synchronous to clk_i. They also assume that each serial clock level lasts at least two system clocks, so the two-stage sampling delay lines up. The bench changes every serial pin on a falling system-clock edge and holds each serial level for four system clocks. It also sets up data four clocks before each rising serial edge. It samples dq_o just before the rising serial edge, the same point a host would sample.

// File: rtl/qxip_pkg.sv
package qxip_pkg;
  typedef enum logic [2:0] {
    ST_OPC, ST_CFG, ST_ADDR, ST_DUMMY, ST_DATA, ST_SKIP
  } qxip_state_e;

  localparam logic [7:0] OPC_CFG_WR = 8'h81;
  localparam logic [7:0] OPC_QREAD  = 8'hEB;
  localparam logic [7:0] CFG_RESET  = 8'hFF;
  localparam int unsigned QUAD_W    = 4;

  function automatic logic [7:0] fill_byte(int unsigned i);
    logic [31:0] p;
    p = i * 29;
    return p[7:0] ^ 8'h5A;
  endfunction
endpackage

// File: rtl/qxip_in_sync.sv
module qxip_in_sync #(
  parameter int unsigned DQ_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_i,
  input  logic            cs_ni,
  input  logic [DQ_W-1:0] dq_i,
  output logic            rise_o,
  output logic            fall_o,
  output logic            sel_o,
  output logic [DQ_W-1:0] dq_o
);
  logic sclk_q, sclk_qq, cs_q;
  logic [DQ_W-1:0] dq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      cs_q    <= 1'b1;
      dq_q    <= '0;
    end else begin
      sclk_q  <= sclk_i;
      sclk_qq <= sclk_q;
      cs_q    <= cs_ni;
      dq_q    <= dq_i;
    end
  end

  assign rise_o = sclk_q & ~sclk_qq;
  assign fall_o = ~sclk_q & sclk_qq;
  assign sel_o  = ~cs_q;
  assign dq_o   = dq_q;
endmodule

// File: rtl/qxip_array.sv
module qxip_array #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  logic [7:0] mem_q [DEPTH];

  // contents are loaded at reset; there is no write path in scope
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= qxip_pkg::fill_byte(i);
    end
  end

  assign byte_o = mem_q[idx_i];
endmodule

// File: rtl/qxip_seq.sv
module qxip_seq
  import qxip_pkg::*;
#(
  parameter int unsigned ADDR_W       = 24,
  parameter int unsigned IDX_W        = 6,
  parameter bit          DIRECT_ENTRY = 1'b0,
  localparam int unsigned ADDR_CLKS   = ADDR_W / QUAD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sel_i,
  input  logic [QUAD_W-1:0] dq_i,
  input  logic [7:0]        rd_byte_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [QUAD_W-1:0] dq_o,
  output logic [QUAD_W-1:0] dq_oe_o,
  output logic              xip_o,
  output logic [7:0]        cfg_o
);
  qxip_state_e state_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        cfg_q;
  logic              xip_q, nib_q, oe_q;
  logic [QUAD_W-1:0] dq_q;

  logic [7:0] sh_nxt;
  logic [3:0] dummy_last;
  logic       enter_ok;

  assign sh_nxt     = {sh_q[6:0], dq_i[0]};
  assign dummy_last = (cfg_q[7:4] == 4'd0) ? 4'd0 : cfg_q[7:4] - 4'd1;
  assign enter_ok   = xip_q | ~cfg_q[3] | DIRECT_ENTRY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OPC;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      cfg_q   <= CFG_RESET;
      xip_q   <= 1'b0;
      nib_q   <= 1'b0;
      oe_q    <= 1'b0;
      dq_q    <= '0;
    end else if (!sel_i) begin
      state_q <= xip_q ? ST_ADDR : ST_OPC;
      cnt_q   <= '0;
      nib_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_OPC: if (rise_i) begin
          sh_q  <= sh_nxt;
          cnt_q <= cnt_q + 4'd1;
          if (cnt_q == 4'd7) begin
            cnt_q <= '0;
            if (sh_nxt == OPC_CFG_WR)     state_q <= ST_CFG;
            else if (sh_nxt == OPC_QREAD) state_q <= ST_ADDR;
            else                          state_q <= ST_SKIP;
          end
        end
        ST_CFG: if (rise_i) begin
          sh_q  <= sh_nxt;
          cnt_q <= cnt_q + 4'd1;
          if (cnt_q == 4'd7) begin
            cfg_q   <= sh_nxt;
            state_q <= ST_SKIP;
          end
        end
        ST_ADDR: if (rise_i) begin
          addr_q <= {addr_q[ADDR_W-QUAD_W-1:0], dq_i};
          cnt_q  <= cnt_q + 4'd1;
          if (cnt_q == 4'(ADDR_CLKS - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_DUMMY;
          end
        end
        ST_DUMMY: if (rise_i) begin
          // confirm bit lives in the first dummy clock
          if (cnt_q == 4'd0) begin
            if (dq_i[0])       xip_q <= 1'b0;
            else if (enter_ok) xip_q <= 1'b1;
          end
          cnt_q <= cnt_q + 4'd1;
          if (cnt_q == dummy_last) begin
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: if (fall_i) begin
          oe_q  <= 1'b1;
          dq_q  <= nib_q ? rd_byte_i[3:0] : rd_byte_i[7:4];
          nib_q <= ~nib_q;
          if (nib_q) addr_q <= addr_q + ADDR_W'(1);
        end
        ST_SKIP: ;
        default: state_q <= ST_SKIP;
      endcase
    end
  end

  assign idx_o   = addr_q[IDX_W-1:0];
  assign dq_o    = dq_q;
  assign dq_oe_o = {QUAD_W{oe_q}};
  assign xip_o   = xip_q;
  assign cfg_o   = cfg_q;
endmodule

// File: rtl/qspi_xip_engine.sv
module qspi_xip_engine #(
  parameter int unsigned MEM_DEPTH    = 64,
  parameter int unsigned ADDR_W       = 24,
  parameter bit          DIRECT_ENTRY = 1'b0,
  localparam int unsigned IDX_W       = $clog2(MEM_DEPTH)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic [3:0] dq_i,
  output logic [3:0] dq_o,
  output logic [3:0] dq_oe_o,
  output logic       xip_o
);
  logic             rise, fall, sel;
  logic [3:0]       dq_s;
  logic [IDX_W-1:0] idx;
  logic [7:0]       rd_byte;
  logic [7:0]       cfg_q;

  qxip_in_sync #(.DQ_W(4)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .dq_i,
    .rise_o(rise), .fall_o(fall), .sel_o(sel), .dq_o(dq_s)
  );

  qxip_array #(.DEPTH(MEM_DEPTH)) u_array (
    .clk_i, .rst_ni, .idx_i(idx), .byte_o(rd_byte)
  );

  qxip_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DIRECT_ENTRY(DIRECT_ENTRY)) u_seq (
    .clk_i, .rst_ni,
    .rise_i(rise), .fall_i(fall), .sel_i(sel), .dq_i(dq_s),
    .rd_byte_i(rd_byte), .idx_o(idx),
    .dq_o, .dq_oe_o, .xip_o, .cfg_o(cfg_q)
  );
endmodule

// File: rtl/qspi_xip_checker.sv
module qspi_xip_checker #(
  parameter bit DIRECT_ENTRY = 1'b0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sclk_i,
  input logic       cs_ni,
  input logic [3:0] dq_i,
  input logic [3:0] dq_o,
  input logic [3:0] dq_oe_o,
  input logic       xip_o,
  input logic [7:0] cfg_i
);
  AST_DESEL_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni, 2) |-> dq_oe_o == 4'h0);  // R8
  AST_DESEL_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni, 2) |-> $stable(xip_o));  // R8
  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(dq_o) || $rose(dq_oe_o[0])) |-> !$past(sclk_i, 2));  // R10
  AST_ENTRY_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xip_o) |-> (DIRECT_ENTRY || !cfg_i[3]));  // R4
  AST_ENTRY_CONFIRM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xip_o) |-> !$past(dq_i[0], 2));  // R4
  AST_EXIT_CONFIRM_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xip_o) |-> $past(dq_i[0], 2));  // R5
endmodule

bind qspi_xip_engine qspi_xip_checker #(.DIRECT_ENTRY(DIRECT_ENTRY)) u_chk (
  .clk_i, .rst_ni, .sclk_i, .cs_ni, .dq_i, .dq_o, .dq_oe_o, .xip_o, .cfg_i(cfg_q)
);

// File: tb/qspi_xip_engine_tb_top.sv
module qspi_xip_engine_tb_top;
  localparam int unsigned DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic [3:0] dq_drv = '0;
  logic [3:0] dq_o, dq_oe;
  logic xip;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qspi_xip_engine #(.MEM_DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n),
    .dq_i(dq_drv), .dq_o(dq_o), .dq_oe_o(dq_oe), .xip_o(xip)
  );

  function automatic logic [7:0] exp_byte(int unsigned a);
    int unsigned i;
    logic [31:0] p;
    i = a % DEPTH;
    p = i * 29;
    return p[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one serial clock: data set while low, sample before the rising edge
  task automatic spi_cyc(input logic [3:0] d, output logic [3:0] q, output logic [3:0] oe);
    dq_drv = d;
    repeat (4) @(negedge clk);
    q = dq_o;
    oe = dq_oe;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_single(input logic [7:0] b, input string req);
    logic [3:0] q, oe;
    for (int i = 7; i >= 0; i--) begin
      spi_cyc({3'b000, b[i]}, q, oe);
      if (i == 0) chk(oe == 4'h0, req, oe, 0);
    end
  endtask

  task automatic send_addr(input logic [23:0] a, input int nclk);
    logic [3:0] q, oe;
    for (int k = 5; k > 5 - nclk; k--) spi_cyc(a[4*k +: 4], q, oe);
  endtask

  task automatic dummies(input int n, input bit conf);
    logic [3:0] q, oe;
    for (int i = 0; i < n; i++) begin
      spi_cyc(i == 0 ? {3'b000, conf} : 4'h0, q, oe);
      chk(oe == 4'h0, "R3 oe low in dummy", oe, 0);
    end
  endtask

  task automatic read_bytes(input int unsigned a, input int n, input string req);
    logic [3:0] hi, lo, oe1, oe2;
    for (int b = 0; b < n; b++) begin
      spi_cyc(4'h0, hi, oe1);
      spi_cyc(4'h0, lo, oe2);
      chk({hi, lo} == exp_byte(a + b) && oe1 == 4'hF && oe2 == 4'hF, req,
          {oe1, oe2, hi, lo}, {8'hFF, exp_byte(a + b)});
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    sel();
    send_single(8'h81, "R2 no drive during opcode");
    send_single(v, "R2 no drive during cfg byte");
    desel();
  endtask

  task automatic quad_read(input bit with_opc, input logic [23:0] a, input int nd,
                           input bit conf, input int n, input string req);
    sel();
    if (with_opc) send_single(8'hEB, "R3 no drive during opcode");
    send_addr(a, 6);
    dummies(nd, conf);
    read_bytes(a, n, req);
    desel();
  endtask

  task automatic t_reset();
    chk(dq_oe == 4'h0, "R1 oe after reset", dq_oe, 0);
    chk(xip == 1'b0, "R1 xip after reset", xip, 0);
  endtask

  task automatic t_plain_read();
    quad_read(1'b1, 24'h000010, 15, 1'b1, 3, "R3 R1 read with default 15 dummies");
    chk(dq_oe == 4'h0, "R8 oe after deselect", dq_oe, 0);
    chk(xip == 1'b0, "R5 confirm high keeps normal mode", xip, 0);
  endtask

  task automatic t_unarmed();
    write_cfg(8'h6F);
    quad_read(1'b1, 24'h000020, 6, 1'b0, 2, "R2 six dummies after cfg write");
    chk(xip == 1'b0, "R4 confirm low without arm ignored", xip, 0);
  endtask

  task automatic t_unknown();
    logic [3:0] q, oe;
    sel();
    send_single(8'h03, "R9 unknown opcode");
    for (int i = 0; i < 24; i++) begin
      spi_cyc(4'h0, q, oe);
      chk(oe == 4'h0, "R9 no drive after unknown opcode", oe, 0);
    end
    desel();
    chk(xip == 1'b0, "R9 mode unchanged", xip, 0);
    quad_read(1'b1, 24'h000004, 6, 1'b1, 1, "R9 cfg unchanged by unknown opcode");
  endtask

  task automatic t_arm_enter();
    write_cfg(8'h67);
    chk(xip == 1'b0, "R4 arming alone does not enter", xip, 0);
    quad_read(1'b1, 24'hAB003E, 6, 1'b0, 4, "R7 wrap across array end");
    chk(xip == 1'b1, "R4 enter after armed read", xip, 1);
  endtask

  task automatic t_xip_cont();
    quad_read(1'b0, 24'h000105, 6, 1'b0, 2, "R6 address-first transfer");
    chk(xip == 1'b1, "R6 stays in mode", xip, 1);
  endtask

  task automatic t_abort();
    sel();
    send_addr(24'h000030, 3);
    desel();
    chk(dq_oe == 4'h0, "R8 abort leaves lines released", dq_oe, 0);
    chk(xip == 1'b1, "R8 abort keeps mode", xip, 1);
    quad_read(1'b0, 24'h000007, 6, 1'b0, 1, "R8 next transfer after abort");
  endtask

  task automatic t_mode3();
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    send_addr(24'h000009, 6);
    dummies(6, 1'b0);
    read_bytes(9, 2, "R10 mode 3 read");
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    desel();
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_exit();
    quad_read(1'b0, 24'h000012, 6, 1'b1, 1, "R5 data still returned on exit");
    chk(xip == 1'b0, "R5 exit on confirm high", xip, 0);
    quad_read(1'b1, 24'h000011, 6, 1'b1, 2, "R6 opcode needed after exit");
  endtask

  task automatic t_min_dummy();
    write_cfg(8'h0F);
    quad_read(1'b1, 24'h000002, 1, 1'b1, 2, "R3 zero dummy field means one");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain_read();
    t_unarmed();
    t_unknown();
    t_arm_enter();
    t_xip_cont();
    t_abort();
    t_mode3();
    t_exit();
    t_min_dummy();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule